// File: doc/BRIEF.md
# Audio Sample DAC Streaming Controller

This peripheral accepts 32-bit audio words from a small register bus, written either by software or by a DMA engine, and plays them out to an external 8-bit DAC. Two sample formats are handled. In 16-bit stereo, one word holds a left and a right sample. In 8-bit mono, one word holds four samples. Playback runs at one of four rates: 44.1 kHz, 22.05 kHz, 11.025 kHz or 8 kHz. The rates are derived from the 3.6864 MHz peripheral clock by a fractional phase accumulator.

Each sample is presented on a shared byte-wide DAC bus. The high byte is driven while the conversion clock is high and the low byte while it is low. A per-channel ready strobe then marks the channel whose data is stable. When the upper half of the current word starts to play, the block raises a DMA request and an interrupt, and both stay up until a new word arrives. If a word is needed while the request is still open, the last sample is replayed and a sticky underrun flag is set. A control bit drives the DAC power-down output.

Top module: `snd_dac_stream`

## Requirements
- R1: While enabled, a 24-bit phase word gains round(rate × 2^24 / CLK_HZ) every clock. A carry out of bit 23 starts one output frame on the next clock. The rate field is control bits [3:2]: 0 = 44.1 kHz, 1 = 22.05 kHz, 2 = 11.025 kHz, 3 = 8 kHz.
- R2: Control bit 1 selects the format. With 1 (stereo), each frame plays a left slot from word bits [15:0] and then a right slot from bits [31:16]. With 0 (mono), each frame plays one slot, taking bytes 0, 1, 2, 3 of the word in that order, and the low output byte of a mono sample is zero.
- R3: A slot lasts 2 × BYTE_CYCLES clocks. For the first BYTE_CYCLES clocks, conv_clk is high and dac_byte carries the sample's upper byte. For the rest, conv_clk is low and dac_byte carries the lower byte. Outside a slot, conv_clk and dac_byte are 0.
- R4: left_ready is high during the low half of a left slot and right_ready during the low half of a right slot. Mono slots count as left. The two strobes are never high together.
- R5: dma_req and irq rise together at the start of the slot that plays the word's upper half: the right slot in stereo, byte 2 in mono. Both stay high until the data register is written.
- R6: dac_pwrdn follows control bit 4.
- R7: A write happens when bus_strobe, bus_write and bus_sel are all high. Address 0 is control, with en at bit 0, stereo at bit 1, rate at bits [3:2] and power-down at bit 4. Address 1 is the 32-bit data word. Address 2 is status, with request at bit 0 and underrun at bit 1. Writes to other addresses are ignored. bus_oe is high exactly while bus_sel is high and bus_write is low, and unmapped addresses read as 0.
- R8: A write with bus_dma_sel high always loads the data register, whatever bus_addr holds, and leaves control unchanged.
- R9: If a frame needs a new word while the request is still high, the underrun flag (status bit 1) is set, the previous sample is replayed and the word position does not advance. Writing 1 to status bit 1 clears the flag.
- R10: Clearing control bit 0 stops the pacing, clears the request and the word position, and returns the DAC outputs to idle within one clock.
- R11: After reset, every output is 0 and control and status read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access select |
| bus_dma_sel | input | 1 | Access comes from the DMA engine |
| bus_strobe | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_oe | output | 1 | Read data drive enable |
| dma_req | output | 1 | Refill request to the DMA engine |
| irq | output | 1 | Refill interrupt |
| dac_byte | output | 8 | Byte-wide DAC data |
| conv_clk | output | 1 | Conversion clock; high selects upper byte |
| left_ready | output | 1 | Left channel data stable |
| right_ready | output | 1 | Right channel data stable |
| dac_pwrdn | output | 1 | DAC power-down |

## Verification
Stereo playback at 44.1 kHz uses words whose two halves differ in every byte, so any swap of left and right or of high and low byte shows up. Mono playback at 8 kHz checks the byte order within a word and the zero low byte. The 22.05 and 11.025 kHz runs check that the rate select reaches the accumulator. Letting the refill queue run dry forces the underrun path, which tells a replayed sample apart from a stale or advanced one. Writes to unmapped addresses and DMA writes carrying a control address show whether the decode keeps the two sources apart.

// File: rtl/snd_pkg.sv
`timescale 1ns/1ps
package snd_pkg;

   typedef struct packed {
      logic       pd;
      logic [1:0] rate;
      logic       stereo;
      logic       en;
   } ctrl_t;

   localparam logic [2:0] ADDR_CTRL = 3'd0;
   localparam logic [2:0] ADDR_DATA = 3'd1;
   localparam logic [2:0] ADDR_STAT = 3'd2;

   function automatic longint unsigned rate_hz(input int idx);
      case (idx)
         0:       return 64'd44100;
         1:       return 64'd22050;
         2:       return 64'd11025;
         default: return 64'd8000;
      endcase
   endfunction

   // rounded per-clock phase step for the selected rate
   function automatic longint unsigned phase_inc(input longint unsigned clk_hz,
                                                 input int idx, input int acc_w);
      return ((rate_hz(idx) << acc_w) + clk_hz / 2) / clk_hz;
   endfunction

endpackage

// File: rtl/snd_regs.sv
`timescale 1ns/1ps
module snd_regs
   import snd_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              dma_sel,
   input  logic              strobe,
   input  logic              write,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              req,
   input  logic              unr_set,
   output ctrl_t             ctrl_q,
   output logic [DATA_W-1:0] data_q,
   output logic              data_wr,
   output logic              unr_q,
   output logic [DATA_W-1:0] rdata,
   output logic              oe
);
   localparam int CTRL_W = $bits(ctrl_t);

   logic wr_any, cpu_wr, ctrl_wr, unr_clr;

   assign wr_any  = strobe & write;
   assign cpu_wr  = wr_any & sel & ~dma_sel;
   assign data_wr = wr_any & (dma_sel | (sel & (addr == ADDR_W'(ADDR_DATA))));
   assign ctrl_wr = cpu_wr & (addr == ADDR_W'(ADDR_CTRL));
   assign unr_clr = cpu_wr & (addr == ADDR_W'(ADDR_STAT)) & wdata[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         data_q <= '0;
         unr_q  <= 1'b0;
      end else begin
         if (ctrl_wr) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
         if (data_wr) data_q <= wdata;
         if (unr_set)      unr_q <= 1'b1;
         else if (unr_clr) unr_q <= 1'b0;
      end
   end

   assign oe = sel & ~write;

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_W'(ADDR_CTRL): rdata[CTRL_W-1:0] = ctrl_q;
         ADDR_W'(ADDR_DATA): rdata = data_q;
         ADDR_W'(ADDR_STAT): rdata[1:0] = {unr_q, req};
         default:            rdata = '0;
      endcase
   end
endmodule

// File: rtl/snd_pacer.sv
`timescale 1ns/1ps
module snd_pacer
   import snd_pkg::*;
#(
   parameter int unsigned CLK_HZ = 3686400,
   parameter int          ACC_W  = 24,
   parameter int          N_RATE = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [1:0] rate,
   output logic       tick
);
   logic [ACC_W-1:0] inc_tab [N_RATE];
   logic [ACC_W-1:0] phase_q;
   logic [ACC_W:0]   sum;

   generate
      if (ACC_W < 8 || ACC_W > 30) begin : g_bad_acc
         $error("snd_pacer: ACC_W out of range");
      end
      for (genvar g = 0; g < N_RATE; g++) begin : g_inc
         localparam longint unsigned STEP = phase_inc(CLK_HZ, g, ACC_W);
         if (STEP == 0 || STEP >= (longint'(1) << ACC_W)) begin : g_bad_step
            $error("snd_pacer: rate step does not fit the accumulator");
         end
         assign inc_tab[g] = ACC_W'(STEP);
      end
   endgenerate

   assign sum = {1'b0, phase_q} + {1'b0, inc_tab[rate]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         tick    <= 1'b0;
      end else if (!en) begin
         phase_q <= '0;
         tick    <= 1'b0;
      end else begin
         phase_q <= sum[ACC_W-1:0];
         tick    <= sum[ACC_W];
      end
   end
endmodule

// File: rtl/snd_serial.sv
`timescale 1ns/1ps
module snd_serial #(
   parameter int BYTE_CYCLES = 4,
   parameter int DATA_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              stereo,
   input  logic              tick,
   input  logic [DATA_W-1:0] word,
   input  logic              data_wr,
   output logic              req,
   output logic              starve,
   output logic              conv_clk,
   output logic [7:0]        dac_byte,
   output logic              left_rdy,
   output logic              right_rdy
);
   localparam int SLOT   = 2 * BYTE_CYCLES;
   localparam int CW     = $clog2(SLOT);
   localparam int SAMP_W = 16;

   logic              busy, chan, rep;
   logic [CW-1:0]     cnt;
   logic [1:0]        pos;
   logic [SAMP_W-1:0] samp, last;
   logic [7:0]        hold;
   logic              slot_end, start_right, need_word, req_rise;
   logic [SAMP_W-1:0] mono_samp;

   generate
      if (BYTE_CYCLES < 1) begin : g_bad_bc
         $error("snd_serial: BYTE_CYCLES must be positive");
      end
      if (DATA_W != 32) begin : g_bad_dw
         $error("snd_serial: word must be 32 bits");
      end
   endgenerate

   assign slot_end    = busy && (cnt == CW'(SLOT - 1));
   assign start_right = slot_end && stereo && !chan;
   assign need_word   = stereo || (pos == 2'd0);
   assign starve      = en && tick && need_word && req;
   assign req_rise    = (tick && !starve && !stereo && pos == 2'd2) ||
                        (start_right && !rep);

   always_comb begin
      case (pos)
         2'd0:    mono_samp = {word[7:0],   8'h00};
         2'd1:    mono_samp = {word[15:8],  8'h00};
         2'd2:    mono_samp = {word[23:16], 8'h00};
         default: mono_samp = {hold,        8'h00};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; chan <= 1'b0; rep <= 1'b0; cnt <= '0; pos <= '0;
         samp <= '0;   last <= '0;   hold <= '0; req <= 1'b0;
      end else if (!en) begin
         busy <= 1'b0; chan <= 1'b0; rep <= 1'b0; cnt <= '0; pos <= '0;
         samp <= '0;   last <= '0;   req <= 1'b0;
      end else begin
         if (tick) begin
            busy <= 1'b1;
            cnt  <= '0;
            chan <= 1'b0;
            rep  <= starve;
            if (starve) begin
               samp <= last;
            end else if (stereo) begin
               samp <= word[15:0];
               last <= word[15:0];
            end else begin
               samp <= mono_samp;
               last <= mono_samp;
               pos  <= pos + 2'd1;
               if (pos == 2'd2) hold <= word[31:24];
            end
         end else if (start_right) begin
            chan <= 1'b1;
            cnt  <= '0;
            if (!rep) begin
               samp <= word[31:16];
               last <= word[31:16];
            end
         end else if (slot_end) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else if (busy) begin
            cnt <= cnt + 1'b1;
         end
         if (data_wr)       req <= 1'b0;
         else if (req_rise) req <= 1'b1;
      end
   end

   assign conv_clk  = busy && (cnt < CW'(BYTE_CYCLES));
   assign dac_byte  = !busy ? 8'h00 : (conv_clk ? samp[15:8] : samp[7:0]);
   assign left_rdy  = busy && !conv_clk && !chan;
   assign right_rdy = busy && !conv_clk && chan;
endmodule

// File: rtl/snd_dac_stream.sv
`timescale 1ns/1ps
module snd_dac_stream
   import snd_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 3686400,
   parameter int          ACC_W       = 24,
   parameter int          BYTE_CYCLES = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_dma_sel,
   input  logic        bus_strobe,
   input  logic        bus_write,
   input  logic [2:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        bus_oe,
   output logic        dma_req,
   output logic        irq,
   output logic [7:0]  dac_byte,
   output logic        conv_clk,
   output logic        left_ready,
   output logic        right_ready,
   output logic        dac_pwrdn
);
   localparam int              DATA_W     = 32;
   localparam int              ADDR_W     = 3;
   localparam longint unsigned FAST_STEP  = phase_inc(CLK_HZ, 0, ACC_W);
   localparam longint unsigned MIN_PERIOD = (longint'(1) << ACC_W) / FAST_STEP;

   generate
      if (4 * BYTE_CYCLES >= MIN_PERIOD) begin : g_bad_frame
         $error("snd_dac_stream: a stereo frame outlasts the fastest sample period");
      end
   endgenerate

   ctrl_t              ctrl_q;
   logic [DATA_W-1:0]  data_q;
   logic               data_wr, unr_flag, req, starve, tick, ctrl_en;

   assign ctrl_en = ctrl_q.en;

   snd_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .sel(bus_sel), .dma_sel(bus_dma_sel),
      .strobe(bus_strobe), .write(bus_write), .addr(bus_addr), .wdata(bus_wdata),
      .req(req), .unr_set(starve), .ctrl_q(ctrl_q), .data_q(data_q),
      .data_wr(data_wr), .unr_q(unr_flag), .rdata(bus_rdata), .oe(bus_oe)
   );

   snd_pacer #(.CLK_HZ(CLK_HZ), .ACC_W(ACC_W), .N_RATE(4)) pacer_i (
      .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .rate(ctrl_q.rate), .tick(tick)
   );

   snd_serial #(.BYTE_CYCLES(BYTE_CYCLES), .DATA_W(DATA_W)) serial_i (
      .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .stereo(ctrl_q.stereo),
      .tick(tick), .word(data_q), .data_wr(data_wr), .req(req), .starve(starve),
      .conv_clk(conv_clk), .dac_byte(dac_byte), .left_rdy(left_ready),
      .right_rdy(right_ready)
   );

   assign dma_req   = req;
   assign irq       = req;
   assign dac_pwrdn = ctrl_q.pd;
endmodule

// File: rtl/snd_dac_stream_chk.sv
`timescale 1ns/1ps
module snd_dac_stream_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       en,
   input logic       conv_clk,
   input logic [7:0] dac_byte,
   input logic       left_ready,
   input logic       right_ready,
   input logic       dma_req,
   input logic       data_wr,
   input logic       underrun
);
   assert_strobes_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(left_ready && right_ready));

   assert_strobe_low_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (left_ready || right_ready) |-> !conv_clk);

   assert_req_drops_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> !dma_req);

   assert_req_rises_at_slot_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_req) |-> conv_clk);

   assert_underrun_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underrun) |-> $past(dma_req));

   assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!conv_clk && dac_byte == 8'h00));
endmodule

bind snd_dac_stream snd_dac_stream_chk chk_i (
   .clk(clk), .rst_n(rst_n), .en(ctrl_en), .conv_clk(conv_clk), .dac_byte(dac_byte),
   .left_ready(left_ready), .right_ready(right_ready), .dma_req(dma_req),
   .data_wr(data_wr), .underrun(unr_flag)
);

// File: tb/snd_dac_stream_tb.sv
`timescale 1ns/1ps
module snd_dac_stream_tb_top;
   localparam int unsigned CLK_HZ = 3686400;
   localparam int          BC     = 4;
   localparam int          SLOT   = 2 * BC;
   localparam longint      WRAP   = longint'(1) << 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_sel = 0, bus_dma_sel = 0, bus_strobe = 0, bus_write = 0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic bus_oe, dma_req, irq, conv_clk, left_ready, right_ready, dac_pwrdn;
   logic [7:0] dac_byte;

   always #5 clk = ~clk;

   snd_dac_stream dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_dma_sel(bus_dma_sel),
      .bus_strobe(bus_strobe), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_oe(bus_oe),
      .dma_req(dma_req), .irq(irq), .dac_byte(dac_byte), .conv_clk(conv_clk),
      .left_ready(left_ready), .right_ready(right_ready), .dac_pwrdn(dac_pwrdn)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   bit m_en, m_st, m_pd;
   bit [1:0] m_rate;
   bit [31:0] m_buf;
   bit m_req, m_unr, m_tick, m_busy, m_chan, m_rep;
   longint m_phase;
   int m_cnt, m_pos;
   bit [15:0] m_samp, m_last;
   bit [7:0] m_hold;

   function automatic longint step_for(input bit [1:0] r);
      longint hz;
      case (r)
         2'd0: hz = 44100;
         2'd1: hz = 22050;
         2'd2: hz = 11025;
         default: hz = 8000;
      endcase
      return (hz * WRAP + CLK_HZ / 2) / CLK_HZ;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = 0; m_st = 0; m_pd = 0; m_rate = 0; m_buf = 0; m_req = 0; m_unr = 0;
         m_tick = 0; m_busy = 0; m_chan = 0; m_rep = 0; m_phase = 0; m_cnt = 0;
         m_pos = 0; m_samp = 0; m_last = 0; m_hold = 0;
      end else begin
         bit wr, dw, cw, uc, starve, rise, slot_end;
         wr = bus_strobe && bus_write;
         dw = wr && (bus_dma_sel || (bus_sel && bus_addr == 3'd1));
         cw = wr && bus_sel && !bus_dma_sel && bus_addr == 3'd0;
         uc = wr && bus_sel && !bus_dma_sel && bus_addr == 3'd2 && bus_wdata[1];
         starve = 0; rise = 0;
         if (!m_en) begin
            m_busy = 0; m_cnt = 0; m_chan = 0; m_pos = 0; m_req = 0; m_rep = 0;
            m_samp = 0; m_last = 0;
         end else begin
            starve = m_tick && (m_st || m_pos == 0) && m_req;
            slot_end = m_busy && m_cnt == SLOT - 1;
            if (m_tick) begin
               m_busy = 1; m_cnt = 0; m_chan = 0; m_rep = starve;
               if (starve) m_samp = m_last;
               else if (m_st) begin m_samp = m_buf[15:0]; m_last = m_samp; end
               else begin
                  bit [7:0] b;
                  b = (m_pos == 3) ? m_hold : m_buf[8*m_pos +: 8];
                  m_samp = {b, 8'h00}; m_last = m_samp;
                  if (m_pos == 2) begin m_hold = m_buf[31:24]; rise = 1; end
                  m_pos = (m_pos + 1) % 4;
               end
            end else if (slot_end && m_st && !m_chan) begin
               m_chan = 1; m_cnt = 0;
               if (!m_rep) begin m_samp = m_buf[31:16]; m_last = m_samp; rise = 1; end
            end else if (slot_end) begin
               m_busy = 0; m_cnt = 0;
            end else if (m_busy) m_cnt++;
            if (dw) m_req = 0; else if (rise) m_req = 1;
         end
         if (!m_en) begin m_phase = 0; m_tick = 0; end
         else begin
            m_phase += step_for(m_rate);
            m_tick = (m_phase >= WRAP);
            if (m_tick) m_phase -= WRAP;
         end
         if (cw) begin
            m_en = bus_wdata[0]; m_st = bus_wdata[1];
            m_rate = bus_wdata[3:2]; m_pd = bus_wdata[4];
         end
         if (dw) m_buf = bus_wdata;
         if (starve) m_unr = 1; else if (uc) m_unr = 0;
      end
   end

   // cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit conv;
         logic [31:0] rd;
         conv = m_busy && m_cnt < BC;
         chk("R1 R3", "conv_clk", conv_clk, conv);
         chk("R2", "dac_byte", dac_byte,
             !m_busy ? 8'h00 : (conv ? m_samp[15:8] : m_samp[7:0]));
         chk("R4", "left_ready", left_ready, m_busy && !conv && !m_chan);
         chk("R4", "right_ready", right_ready, m_busy && !conv && m_chan);
         chk("R5", "dma_req", dma_req, m_req);
         chk("R5", "irq", irq, m_req);
         chk("R6", "dac_pwrdn", dac_pwrdn, m_pd);
         chk("R7", "bus_oe", bus_oe, bus_sel && !bus_write);
         if (bus_sel && !bus_write) begin
            case (bus_addr)
               3'd0: rd = {27'd0, m_pd, m_rate, m_st, m_en};
               3'd1: rd = m_buf;
               3'd2: rd = {30'd0, m_unr, m_req};
               default: rd = 32'd0;
            endcase
            chk("R7", "bus_rdata", bus_rdata, rd);
         end
      end
   end

   // ---------------- stimulus ----------------
   bit [31:0] words[$];

   task automatic idle_bus();
      bus_sel = 0; bus_dma_sel = 0; bus_strobe = 0; bus_write = 0;
      bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [31:0] d, input bit dma);
      @(negedge clk); #1;
      bus_sel = !dma; bus_dma_sel = dma; bus_strobe = 1; bus_write = 1;
      bus_addr = a; bus_wdata = d;
      @(negedge clk); #1;
      idle_bus();
   endtask

   task automatic bus_rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk); #1;
      bus_sel = 1; bus_strobe = 1; bus_write = 0; bus_addr = a;
      @(negedge clk);
      chk(tag, "register read", bus_rdata, exp);
      #1 idle_bus();
   endtask

   task automatic run(input int n, input bit refill);
      bit drove = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         if (drove) begin idle_bus(); drove = 0; end
         else if (refill && dma_req && words.size() > 0) begin
            bus_dma_sel = 1; bus_strobe = 1; bus_write = 1; bus_wdata = words.pop_front();
            drove = 1;
         end
      end
      if (drove) begin @(negedge clk); #1 idle_bus(); end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R11: reset state
      chk("R11", "reset conv_clk", conv_clk, 0);
      chk("R11", "reset dac_byte", dac_byte, 0);
      chk("R11", "reset dma_req", dma_req, 0);
      bus_rd(3'd0, 32'h0, "R11");
      bus_rd(3'd2, 32'h0, "R11");

      // stereo at 44.1 kHz with DMA refill, then let it run dry
      bus_wr(3'd1, 32'hC3A5_5A3C, 0);
      bus_rd(3'd1, 32'hC3A5_5A3C, "R7");
      words = '{32'h8001_7FFE, 32'h1234_ABCD, 32'hF00F_0FF0, 32'h00FF_FF00};
      bus_wr(3'd0, 32'h3, 0);
      run(600, 1);
      run(400, 0);
      bus_rd(3'd2, 32'h3, "R9");
      bus_wr(3'd0, 32'h2, 0);
      @(negedge clk);
      chk("R10", "idle conv_clk after disable", conv_clk, 0);
      chk("R10", "idle dac_byte after disable", dac_byte, 0);
      bus_rd(3'd2, 32'h2, "R10");
      bus_wr(3'd2, 32'h2, 0);
      bus_rd(3'd2, 32'h0, "R9");

      // decode: unmapped write ignored, DMA write with control address
      bus_wr(3'd5, 32'h1F, 0);
      bus_rd(3'd0, 32'h2, "R7");
      bus_rd(3'd5, 32'h0, "R7");
      bus_wr(3'd0, 32'h4433_2211, 1);
      bus_rd(3'd0, 32'h2, "R8");
      bus_rd(3'd1, 32'h4433_2211, "R8");

      // mono at 8 kHz with power-down, refill then underrun
      words = '{32'h8877_6655, 32'hDDCC_BBAA};
      bus_wr(3'd0, 32'h1D, 0);
      @(negedge clk);
      chk("R6", "dac_pwrdn set", dac_pwrdn, 1);
      run(8000, 1);
      bus_rd(3'd2, 32'h3, "R9");
      bus_wr(3'd0, 32'h0, 0);
      bus_wr(3'd2, 32'h2, 0);

      // stereo at 22.05 kHz and 11.025 kHz
      bus_wr(3'd1, 32'h0102_0304, 0);
      words = '{32'hA0B0_C0D0, 32'h1122_3344, 32'h5566_7788};
      bus_wr(3'd0, 32'h7, 0);
      run(1500, 1);
      bus_wr(3'd0, 32'h0, 0);
      bus_wr(3'd1, 32'hFEDC_BA98, 0);
      words = '{32'h7654_3210, 32'h0F1E_2D3C};
      bus_wr(3'd0, 32'hB, 0);
      run(2000, 1);
      bus_wr(3'd0, 32'h0, 0);
      run(20, 0);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule